// File: doc/BRIEF.md
# Real-time clock interrupt flag and enable logic

This block collects the three interrupt causes of a PC-style real-time clock: the periodic tick, the alarm match and the end of the once-per-second time update. Each cause arrives as a single-cycle strobe from neighbouring logic (rate divider, alarm comparator, update sequencer). Every strobe latches into its own sticky flag. A flag latches whether or not software has enabled that cause. The enables gate only the summary request bit and the interrupt line.

Software talks to the block through a byte-wide register port with two addresses. Address 0 is a read/write control byte. It holds the three enables, in the same bit positions as the flags in the status byte, so one mask works on both registers. It also holds a 24-hour mode bit, a binary data mode bit, a daylight-saving enable bit and two spare bits; the block stores all of these and returns them unchanged. Address 1 is the read-only status byte. Reading it returns the flags and the summary bit and clears them in the same access. Software therefore reads it after changing enables to leave no stale request behind.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, the control byte, the status byte and irq_o are all zero.
- R2: A write with addr_i=0 stores all eight bits of wdata_i in the control byte, and a read of address 0 returns them unchanged. The control byte holds: bit 6 periodic enable, bit 5 alarm enable, bit 4 update enable, bit 2 binary mode, bit 1 24-hour mode, bit 0 daylight-saving enable, and bits 7 and 3 as spare storage.
- R3: A strobe on evt_i[i] sets status bit 4+i at the next clock edge, whatever the state of its enable. Index 0 is update, 1 is alarm and 2 is periodic.
- R4: Status bit 7 (summary) sets at the same edge at which some flag and its matching enable are first both set. This includes the case where an enable is written while its flag is already set. A flag whose enable is clear never sets the summary.
- R5: irq_o always equals status bit 7.
- R6: A read with addr_i=1 and rd_i=1 returns the status byte as it stood before the access. At the next edge it clears all flags and the summary, so irq_o drops one cycle after the read.
- R7: A strobe in the same cycle as a status read is not lost. The read returns the old flags, and the strobe's flag is set after the edge (together with the summary if its enable is set).
- R8: A write to address 1 changes neither the status byte nor the control byte.
- R9: Reading the control byte does not clear any flag or the summary.
- R10: Once set, the summary stays set when the matching enable is later cleared, until a status read or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register select: 0 control, 1 status |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effects only on the status address) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register, combinational |
| evt_i | input | 3 | Event strobes: [0] update ended, [1] alarm, [2] periodic |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench targets the orderings that software depends on. It raises a flag with its enable clear and then turns the enable on; a design that sampled the enable only when the strobe arrived would never interrupt. It lands a strobe in the same cycle as a status read; a design where the clear wins would silently drop that event. It clears an enable while a request is pending, reads the control byte, and writes to the status address. A design that let any of these touch the summary or the flags would drop or retain a request at the wrong time. Single-source events under each enable catch bit positions that are swapped between the two registers.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int NSRC     = 3;  // update, alarm, periodic
  localparam int FLAG_LSB = 4;  // shared by enables and flags
  localparam int SUM_BIT  = 7;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] ctrl_nxt_o
);
  assign ctrl_nxt_o = we_i ? wdata_i : ctrl_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else         ctrl_o <= ctrl_nxt_o;
  end
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [NSRC-1:0] evt_i,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] flags_nxt_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    // event beats the read-clear so no strobe is lost
    assign flags_nxt_o[g] = evt_i[g] | (flags_o[g] & ~clr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_o[g] <= 1'b0;
      else         flags_o[g] <= flags_nxt_o[g];
    end
  end
endmodule

// File: rtl/rtc_irq_summary.sv
module rtc_irq_summary #(
  parameter int NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [NSRC-1:0] flags_nxt_i,
  input  logic [NSRC-1:0] en_nxt_i,
  output logic            sum_o
);
  logic hit;
  assign hit = |(flags_nxt_i & en_nxt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= 1'b0;
    else         sum_o <= (sum_o & ~clr_i) | hit;
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NSRC-1:0]   evt_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_nxt;
  logic [NSRC-1:0]   flags_q, flags_nxt, en_q, en_nxt;
  logic              sum_q, clr, ctrl_we;

  assign ctrl_we = wr_i & (addr_i == ADDR_CTRL);
  assign clr     = rd_i & (addr_i == ADDR_STAT);
  assign en_q    = ctrl_q[FLAG_LSB +: NSRC];
  assign en_nxt  = ctrl_nxt[FLAG_LSB +: NSRC];

  rtc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .we_i(ctrl_we), .wdata_i,
    .ctrl_o(ctrl_q), .ctrl_nxt_o(ctrl_nxt)
  );

  rtc_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk_i, .rst_ni, .clr_i(clr), .evt_i,
    .flags_o(flags_q), .flags_nxt_o(flags_nxt)
  );

  rtc_irq_summary #(.NSRC(NSRC)) u_sum (
    .clk_i, .rst_ni, .clr_i(clr), .flags_nxt_i(flags_nxt),
    .en_nxt_i(en_nxt), .sum_o(sum_q)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o = ctrl_q;
    end else begin
      rdata_o[SUM_BIT]            = sum_q;
      rdata_o[FLAG_LSB +: NSRC]   = flags_q;
    end
  end

  assign irq_o = sum_q;
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk
  import rtc_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [NSRC-1:0]   evt_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [NSRC-1:0]   flags_q,
  input logic [NSRC-1:0]   en_q
);
  a_r3_evt_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  a_r4_rise_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((flags_q & en_q) != '0));

  a_r5_irq_is_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_STAT) |-> (rdata_o[SUM_BIT] == irq_o));

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_STAT && evt_i == '0) |=> (!irq_o && flags_q == '0));

  a_r8_stat_write_keeps_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_STAT) |=> $stable(en_q));

  a_r9_ctrl_read_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_CTRL) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .evt_i(evt_i), .rdata_o(rdata_o), .irq_o(irq_o), .flags_q(flags_q), .en_q(en_q)
);

// File: tb/rtc_irq_ctrl_tb_top.sv
module rtc_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] evt_i = '0;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_ctrl = 0, m_flags = 0, m_sum = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_irq_ctrl dut_i (.*);

  function automatic int exp_read(input logic a);
    if (a) return (m_sum << 7) | (m_flags << 4);
    return m_ctrl;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic w, input logic r,
                      input int d, input int e, input string tag);
    bit clr;
    @(negedge clk_i);
    addr_i = a; wr_i = w; rd_i = r; wdata_i = d[7:0]; evt_i = e[2:0];
    #1;
    chk(int'(rdata_o), exp_read(a), {tag, " rdata"});
    chk(int'(irq_o), m_sum, {tag, " irq"});
    @(posedge clk_i);
    clr = r && a;
    if (w && !a) m_ctrl = d & 8'hff;
    m_flags = (clr ? 0 : m_flags) | (e & 7);
    m_sum   = ((clr ? 0 : m_sum) != 0 || ((m_flags & (m_ctrl >> 4) & 7) != 0)) ? 1 : 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: state during and right after reset
    #(CLK_PERIOD * 2);
    chk(int'(irq_o), 0, "R1 irq in reset");
    chk(int'(rdata_o), 0, "R1 ctrl in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    step(1, 0, 0, 0, 0, "R1 status after reset");
    step(0, 0, 0, 0, 0, "R1 ctrl after reset");
    // R2: full byte stored and returned
    step(0, 1, 0, 8'hff, 0, "R2 write ff");
    step(0, 0, 1, 0, 0, "R2 readback ff");
    step(0, 1, 0, 8'h8f, 0, "R2 write modes+spare");
    step(0, 0, 0, 0, 0, "R2 readback 8f");
    // R3: flags latch with enables clear, R4 no summary
    step(0, 0, 0, 0, 3'b111, "R3 all events");
    step(1, 0, 0, 0, 0, "R3 R4 flags set no irq");
    // R9: control read keeps flags
    step(0, 0, 1, 0, 0, "R9 ctrl read");
    step(1, 0, 0, 0, 0, "R9 flags kept");
    // R8: status write ignored
    step(1, 1, 0, 8'hff, 0, "R8 status write");
    step(1, 0, 0, 0, 0, "R8 status unchanged");
    step(0, 0, 0, 0, 0, "R8 ctrl unchanged");
    // R4: enabling a pending flag raises summary at the write edge
    step(0, 1, 0, 8'h20, 0, "R4 enable alarm");
    step(1, 0, 0, 0, 0, "R4 R5 summary set");
    // R10: clearing the enable keeps the summary
    step(0, 1, 0, 8'h00, 0, "R10 disable");
    step(1, 0, 0, 0, 0, "R10 summary held");
    // R6: status read returns old and clears
    step(1, 0, 1, 0, 0, "R6 status read");
    step(1, 0, 0, 0, 0, "R6 cleared");
    // R3 R4 single sources with own enables
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 0, (1 << (4 + i)), 0, "R4 set single enable");
      step(0, 0, 0, 0, (1 << ((i + 1) % 3)), "R4 other source only");
      step(1, 0, 0, 0, 0, "R4 unmatched no irq");
      step(1, 0, 0, 0, (1 << i), "R3 matched event");
      step(1, 0, 0, 0, 0, "R5 irq on match");
      step(1, 0, 1, 0, 0, "R6 read clears");
    end
    // R7: event during read survives
    step(0, 1, 0, 8'h70, 0, "R7 enable all");
    step(1, 0, 0, 0, 3'b010, "R7 alarm event");
    step(1, 0, 1, 0, 3'b001, "R7 read with update event");
    step(1, 0, 0, 0, 0, "R7 update flag kept");
    step(1, 0, 1, 0, 0, "R6 final read");
    step(1, 0, 0, 0, 0, "R6 final clear");
    // R7 with enable clear: flag kept, no summary
    step(0, 1, 0, 8'h00, 0, "R7 disable all");
    step(1, 0, 1, 0, 3'b100, "R7 read with periodic event");
    step(1, 0, 0, 0, 0, "R7 periodic flag no irq");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule